// File: doc/BRIEF.md
# Receive Lane Ready Aggregator

This block follows the data-ready state of up to sixteen receive lanes of a serial audio port. Each lane's shifter gives a one-cycle pulse when it moves a finished word into that lane's holding buffer. The host side gives a one-cycle pulse when it reads that buffer. The block keeps one ready bit per lane. It folds the bits of the lanes marked active into a single global ready flag.

The global flag drives two outputs toward the host, each gated by its own enable. The first is a one-cycle DMA request raised when the flag rises. The second is a level interrupt that is high while the flag is set. A small register window lets the host read each lane's ready bit and the global flag. Through the same window the host clears the global flag by writing a one, and sets the lane-active mask and the two enables.

Top module: `rx_ready_agg`

## Requirements
- R1: A transfer pulse on lane n sets that lane's ready bit on the next clock edge, whether or not the lane is active.
- R2: A buffer-read pulse on lane n, with no transfer pulse on lane n in the same cycle, clears that lane's ready bit on the next clock edge.
- R3: When a lane sees a transfer pulse and a buffer-read pulse in the same cycle, its ready bit ends up set.
- R4: The ready bit of lane n reads back as bit 5 at address 0x10+n; all other bits there read 0.
- R5: A transfer pulse on a lane whose bit in the active mask (address 0x00, bit n) is 1 sets the global flag on the next edge. A transfer on a lane whose mask bit is 0 leaves the flag unchanged. The flag reads back as bit 5 of address 0x02.
- R6: Writing address 0x02 with bit 5 at 1 clears the global flag and leaves every lane ready bit unchanged. A transfer on an active lane in the same cycle wins, and the flag stays set. The next active transfer sets the flag again.
- R7: The global flag clears on the edge at which no active lane has its ready bit set, which happens once every pending active lane has been read.
- R8: When the global flag rises and the DMA enable (address 0x01, bit 0) is 1, dma_req is high for exactly one cycle. That cycle is the one just after the transfer that raised the flag, which is well inside the five-clock limit on event latency. No pulse is produced while the flag is already set, and none while the enable is 0.
- R9: irq is high exactly while the global flag is set and the interrupt enable (address 0x01, bit 1) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_xfer | input | NUM_LANES | Per-lane pulse: word moved into the holding buffer |
| lane_buf_rd | input | NUM_LANES | Per-lane pulse: host read the holding buffer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| dma_req | output | 1 | One-cycle receive DMA request |
| irq | output | 1 | Receive ready interrupt level |

## Verification
The assertions assume that lane_xfer and lane_buf_rd are single-cycle pulses sampled at the clock, and that reg_wr lasts one cycle with a stable address and data. They also assume that a buffer read is only issued for a lane whose word the host means to consume. The stimulus drives every input for exactly one cycle after a falling edge and returns it to idle before the next action. Reads, transfers and clear writes are applied in chosen orders, with same-cycle collisions placed on purpose, so the ready and flag precedence rules are exercised without leaving these assumptions.

// File: rtl/rxr_pkg.sv
// Shared constants and types for the receive ready aggregator.
// Assumes at most 32 lanes so the active mask fits one register word.
package rxr_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 32;
    localparam int STAT_BIT = 5;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 5'h00;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 5'h01;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 5'h02;
    localparam int CTRL_DMA_EN = 0;
    localparam int CTRL_IRQ_EN = 1;

    typedef struct packed {
        logic irq_en;
        logic dma_en;
    } ctrl_t;
endpackage

// File: rtl/rxr_lane.sv
// One lane's ready bit: set by a buffer fill, cleared by a host read.
// Assumes both inputs are single-cycle pulses; a fill wins over a read.
module rxr_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer,
    input  logic buf_rd,
    output logic rdy,
    output logic rdy_nxt
);
    // next-state of the ready bit, also used by the global flag
    assign rdy_nxt = xfer | (rdy & ~buf_rd);

    // ready bit register
    always_ff @(posedge clk) begin
        if (!rst_n) rdy <= 1'b0;
        else        rdy <= rdy_nxt;
    end
endmodule

// File: rtl/rxr_regs.sv
// Register window: active mask, enables, clear strobe and readback.
// Assumes reg_wr is a one-cycle strobe; reads are combinational.
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int NUM_LANES = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_LANES-1:0]  lane_rdy,
    input  logic                  flag,
    output logic [NUM_LANES-1:0]  active,
    output ctrl_t                 ctrl,
    output logic                  flag_clr
);
    localparam int IDX_W = ADDR_W - 1;

    logic [IDX_W-1:0] idx;
    logic             unused_wdata;

    assign idx          = reg_addr[IDX_W-1:0];
    assign unused_wdata = ^reg_wdata;

    // write-one-to-clear strobe for the global flag
    assign flag_clr = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[STAT_BIT];

    // active mask and enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= '0;
            ctrl   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_MASK) active <= reg_wdata[NUM_LANES-1:0];
            if (reg_addr == ADDR_CTRL) ctrl <= '{irq_en: reg_wdata[CTRL_IRQ_EN],
                                                dma_en: reg_wdata[CTRL_DMA_EN]};
        end
    end

    // readback mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_MASK) begin
            reg_rdata[NUM_LANES-1:0] = active;
        end else if (reg_addr == ADDR_CTRL) begin
            reg_rdata[CTRL_DMA_EN] = ctrl.dma_en;
            reg_rdata[CTRL_IRQ_EN] = ctrl.irq_en;
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata[STAT_BIT] = flag;
        end else if (reg_addr[ADDR_W-1] && (int'(idx) < NUM_LANES)) begin
            reg_rdata[STAT_BIT] = lane_rdy[idx];
        end
    end
endmodule

// File: rtl/rxr_flag.sv
// Global ready flag with DMA pulse and interrupt level.
// Assumes lane_rdy_nxt is the next-state of each lane ready bit.
module rxr_flag
    import rxr_pkg::*;
#(
    parameter int NUM_LANES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] xfer,
    input  logic [NUM_LANES-1:0] lane_rdy_nxt,
    input  logic [NUM_LANES-1:0] active,
    input  logic                 flag_clr,
    input  ctrl_t                ctrl,
    output logic                 flag,
    output logic                 dma_req,
    output logic                 irq
);
    logic set_evt;
    logic any_pending;
    logic flag_d;

    // an active lane filled its buffer this cycle
    assign set_evt     = |(xfer & active);
    // some active lane will still hold an unread word
    assign any_pending = |(lane_rdy_nxt & active);
    // a fill wins; otherwise hold until cleared or drained
    assign flag_d      = set_evt | (flag & ~flag_clr & any_pending);

    // flag and rise-triggered DMA pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            dma_req <= 1'b0;
        end else begin
            flag    <= flag_d;
            dma_req <= set_evt & ~flag & ctrl.dma_en;
        end
    end

    // interrupt level from registered state only
    assign irq = flag & ctrl.irq_en;
endmodule

// File: rtl/rx_ready_agg.sv
// Top: per-lane ready bits, register window and global flag outputs.
// Assumes lane pulses are synchronous to clk and one cycle wide.
module rx_ready_agg
    import rxr_pkg::*;
#(
    parameter int NUM_LANES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_xfer,
    input  logic [NUM_LANES-1:0] lane_buf_rd,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 dma_req,
    output logic                 irq
);
    logic [NUM_LANES-1:0] lane_rdy;
    logic [NUM_LANES-1:0] lane_rdy_nxt;
    logic [NUM_LANES-1:0] active;
    ctrl_t                ctrl_q;
    logic                 flag_clr;
    logic                 glob_flag;

    // one ready cell per lane
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        rxr_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .xfer    (lane_xfer[g]),
            .buf_rd  (lane_buf_rd[g]),
            .rdy     (lane_rdy[g]),
            .rdy_nxt (lane_rdy_nxt[g])
        );
    end

    rxr_regs #(.NUM_LANES(NUM_LANES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lane_rdy  (lane_rdy),
        .flag      (glob_flag),
        .active    (active),
        .ctrl      (ctrl_q),
        .flag_clr  (flag_clr)
    );

    rxr_flag #(.NUM_LANES(NUM_LANES)) u_flag (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer         (lane_xfer),
        .lane_rdy_nxt (lane_rdy_nxt),
        .active       (active),
        .flag_clr     (flag_clr),
        .ctrl         (ctrl_q),
        .flag         (glob_flag),
        .dma_req      (dma_req),
        .irq          (irq)
    );
endmodule

// File: rtl/rx_ready_agg_chk.sv
// Checker for the aggregator, attached by bind below.
// Assumes lane and register inputs are one-cycle pulses.
module rx_ready_agg_chk #(
    parameter int NUM_LANES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LANES-1:0] xfer,
    input logic [NUM_LANES-1:0] buf_rd,
    input logic [NUM_LANES-1:0] lane_rdy,
    input logic [NUM_LANES-1:0] active,
    input logic                 flag_clr,
    input logic                 flag,
    input logic                 dma_en,
    input logic                 irq_en,
    input logic                 dma_req,
    input logic                 irq
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane_chk
        assert_lane_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
            xfer[i] |=> lane_rdy[i]);
        assert_lane_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_rd[i] && !xfer[i]) |=> !lane_rdy[i]);
        assert_collide_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (buf_rd[i] && xfer[i]) |=> lane_rdy[i]);
    end

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(xfer & active)) |=> flag);
    assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(|(xfer & active))) |=> !flag);
    assert_flag_needs_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (|lane_rdy));
    assert_dma_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> flag);
    assert_dma_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(xfer & active)) && !flag && dma_en) |=> dma_req);
    assert_irq_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && irq_en));
endmodule

bind rx_ready_agg rx_ready_agg_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .xfer     (lane_xfer),
    .buf_rd   (lane_buf_rd),
    .lane_rdy (lane_rdy),
    .active   (active),
    .flag_clr (flag_clr),
    .flag     (glob_flag),
    .dma_en   (ctrl_q.dma_en),
    .irq_en   (ctrl_q.irq_en),
    .dma_req  (dma_req),
    .irq      (irq)
);

// File: tb/rx_ready_agg_tb.sv
// Scoreboard bench: the driver queues expected output pairs per cycle,
// the monitor pops and compares them at the falling edge.
module rx_ready_agg_tb;
    import rxr_pkg::*;

    localparam int NL = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NL-1:0]     lane_xfer = '0;
    logic [NL-1:0]     lane_buf_rd = '0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              dma_req;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int    at;
        logic  dma;
        logic  irq;
        string tag;
    } exp_t;
    exp_t sb[$];

    rx_ready_agg #(.NUM_LANES(NL)) u_dut (
        .clk, .rst_n, .lane_xfer, .lane_buf_rd, .reg_wr,
        .reg_addr, .reg_wdata, .reg_rdata, .dma_req, .irq
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare queued expectations due this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " dma_req"}, {31'b0, dma_req}, {31'b0, e.dma});
            check({e.tag, " irq"},     {31'b0, irq},     {31'b0, e.irq});
        end
    end

    task automatic drive(input logic [NL-1:0] x, input logic [NL-1:0] r,
                         input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        #1;
        lane_xfer = x; lane_buf_rd = r; reg_wr = w; reg_addr = a; reg_wdata = d;
    endtask

    task automatic idle();
        drive('0, '0, 1'b0, '0, '0);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        drive('0, '0, 1'b1, a, d);
    endtask

    // expectation for outputs after the edge that follows the last drive
    task automatic expect_out(input logic d, input logic i, input string tag);
        exp_t e;
        e.at = cyc + 1; e.dma = d; e.irq = i; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic chk_reg(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        drive('0, '0, 1'b0, a, '0);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R9 irq after reset", {31'b0, irq}, 0);
        check("R8 dma_req after reset", {31'b0, dma_req}, 0);
        chk_reg(ADDR_STAT, 32'h0, "R6 status after reset");
        chk_reg(ADDR_MASK, 32'h0, "R5 mask after reset");

        wr(ADDR_CTRL, 32'h3);
        wr(ADDR_MASK, 32'h00FF);
        chk_reg(ADDR_CTRL, 32'h3, "R8 enables readback");

        // inactive lane 12 fills: lane bit sets, flag does not
        drive(16'h1 << 12, '0, 1'b0, '0, '0);
        expect_out(0, 0, "R5 inactive lane ignored");
        chk_reg(5'h1C, 32'h20, "R1 R4 inactive lane bit set");
        chk_reg(ADDR_STAT, 32'h0, "R5 flag stays clear");
        drive('0, 16'h1 << 12, 1'b0, '0, '0);
        chk_reg(5'h1C, 32'h0, "R2 lane12 cleared by read");

        // active lane 3 fills: flag rises, one DMA pulse
        drive(16'h1 << 3, '0, 1'b0, '0, '0);
        expect_out(1, 1, "R8 pulse on rise");
        idle();
        expect_out(0, 1, "R8 single pulse R9 irq level");
        chk_reg(5'h13, 32'h20, "R1 R4 lane3 status");
        chk_reg(ADDR_STAT, 32'h20, "R5 flag set");

        drive(16'h1 << 5, '0, 1'b0, '0, '0);
        expect_out(0, 1, "R8 no pulse while flag set");
        drive('0, 16'h1 << 3, 1'b0, '0, '0);
        expect_out(0, 1, "R7 held while lane5 pending");
        chk_reg(5'h13, 32'h0, "R2 lane3 cleared");
        drive('0, 16'h1 << 5, 1'b0, '0, '0);
        expect_out(0, 0, "R7 cleared after all read");
        chk_reg(ADDR_STAT, 32'h0, "R7 status clear");

        // fill and read of lane 2 in one cycle
        drive(16'h1 << 2, 16'h1 << 2, 1'b0, '0, '0);
        expect_out(1, 1, "R3 collision keeps word");
        chk_reg(5'h12, 32'h20, "R3 lane2 still ready");

        // write-one-to-clear
        wr(ADDR_STAT, 32'h20);
        expect_out(0, 0, "R6 clear by write");
        chk_reg(5'h12, 32'h20, "R6 lane bit untouched");
        chk_reg(ADDR_STAT, 32'h0, "R6 status cleared");
        drive(16'h1, '0, 1'b0, '0, '0);
        expect_out(1, 1, "R6 re-set by next fill");
        drive('0, 16'h5, 1'b0, '0, '0);
        expect_out(0, 0, "R7 drained lanes 0 and 2");

        // fill wins over a clear in the same cycle
        drive(16'h1 << 1, '0, 1'b0, '0, '0);
        expect_out(1, 1, "R8 pulse lane1");
        drive(16'h1 << 4, '0, 1'b1, ADDR_STAT, 32'h20);
        expect_out(0, 1, "R6 fill wins over clear");
        drive('0, 16'h12, 1'b0, '0, '0);
        expect_out(0, 0, "R7 drained lanes 1 and 4");

        // enables gate the outputs
        wr(ADDR_CTRL, 32'h0);
        drive(16'h1 << 6, '0, 1'b0, '0, '0);
        expect_out(0, 0, "R8 R9 outputs disabled");
        chk_reg(ADDR_STAT, 32'h20, "R9 flag set while masked");
        wr(ADDR_CTRL, 32'h2);
        expect_out(0, 1, "R9 irq follows enable");
        drive('0, 16'h1 << 6, 1'b0, '0, '0);
        expect_out(0, 0, "R7 drained lane6");

        repeat (3) idle();
        check("R8 scoreboard drained", sb.size(), 0);
        finished = 1;
        summary();
    end
endmodule